// File: doc/BRIEF.md
# SPI Status Polling Engine

The block is a single-lane SPI master that keeps reading one status byte from a serial flash until a masked bit pattern shows up. Software sets up a command byte, an optional address byte, a bit mask, a match value, a gap length and a clock divider, then pulses `start`. Each poll pulls chip select low and shifts out the command. If enabled, the address follows. One byte is then read back on `miso`. Chip select is released, the byte is masked and compared, and the engine idles for the gap before the next poll. With `auto_stop` set, the first match ends the run. Without it, the engine polls until `abort`.

A short mode with the read phase disabled sends the command byte, plus the address byte when enabled, exactly once and then returns to idle. This suits single-byte commands such as a write-latch set or clear. All set-up inputs are captured on the `start` that launches a run. `busy` stays high from that cycle until the engine is idle again.

The controller has six states:
- IDLE: waiting for a launch.
- INSTR: shifting out the command byte.
- ADDR: shifting out the address byte.
- READ: shifting in the status byte.
- EVAL: one cycle in which the byte is compared.
- GAP: the idle interval between polls, with chip select high.

The transitions are:
- launch: IDLE to INSTR.
- command-to-address: INSTR to ADDR.
- command-to-read: INSTR to READ.
- command-done: INSTR to IDLE.
- address-to-read: ADDR to READ.
- address-done: ADDR to IDLE.
- byte-in: READ to EVAL.
- stop-on-match: EVAL to IDLE.
- retry: EVAL to GAP.
- next-poll: GAP to INSTR.
- abort: any state to IDLE.

Top module: `spi_status_poller`

## Requirements
- R1: After reset `busy`=0, `cs_n`=1, `sck`=0, `match_flag`=0 and `match_hit`=0.
- R2: With divider value D (D=0 acts as 1), one SCK period lasts D+1 clock cycles. `sck` is low for the first floor((D+1)/2) cycles of each bit and high for the rest.
- R3: A frame sends the command byte, then the address byte when `use_addr`=1, both MSB first. When `use_read`=1, eight read clocks follow. The frame has 8, 16 or 24 SCK rising edges, and `mosi` never changes while `sck` is high.
- R4: With `late_sample`=0 each read bit is taken at the SCK rising edge. With `late_sample`=1 it is taken at the falling edge that ends the bit. The first bit received is bit 7 of `status_byte`, which holds the byte of the last completed poll.
- R5: A poll matches when (byte AND `status_mask`) equals `status_match`. A match gives a one-cycle `match_hit` in the first cycle after `cs_n` rises and sets `match_flag`.
- R6: With `auto_stop`=1, the first matching poll ends the run. `busy` falls the cycle after `match_hit`, and no further frame starts.
- R7: With `auto_stop`=0, polling continues after a match, and every matching poll produces its own `match_hit` pulse.
- R8: Between polls `cs_n` stays high, and `sck` stays low, for max(G,1)·(D+1)+1 clock cycles, where G is `gap_periods`.
- R9: With `use_read`=0, exactly one frame is sent and the engine returns to idle. No compare takes place: there is no `match_hit` and `match_flag` keeps its value.
- R10: `flag_clr`=1 clears `match_flag` on the next edge. If a match is detected in the same cycle, the flag ends up set.
- R11: `abort` returns the engine to idle on the next edge with `cs_n` high and overrides a same-cycle `start`. A `start` that arrives while `busy`=1 is ignored, and the frames that follow keep the captured command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Launch pulse; captures the set-up inputs |
| abort | input | 1 | Stops the engine at once |
| cmd_byte | input | DW | Command byte sent first |
| addr_byte | input | DW | Address byte sent second |
| use_addr | input | 1 | Include the address phase |
| use_read | input | 1 | Include the read phase and polling |
| status_mask | input | DW | Bits that take part in the compare |
| status_match | input | DW | Expected value of the masked bits |
| gap_periods | input | IVL_W | SCK periods with chip select high between polls |
| clk_div | input | PSC_W | Divider value D; SCK period is D+1 clocks |
| auto_stop | input | 1 | Stop on the first match |
| late_sample | input | 1 | Sample at the falling edge instead of the rising edge |
| flag_clr | input | 1 | Write-one-to-clear for `match_flag` |
| sck | output | 1 | Serial clock, idle low |
| cs_n | output | 1 | Chip select, active low |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| busy | output | 1 | Engine running |
| match_hit | output | 1 | One-cycle pulse per matching poll |
| match_flag | output | 1 | Sticky match indication |
| status_byte | output | DW | Byte read by the last completed poll |

## Verification
A match can be detected in the same cycle that software writes `flag_clr`. The two must resolve with the flag set. The bench provokes this by running a poll with `auto_stop`=0 against a device that always matches. It waits for `cs_n` to rise, which marks the compare cycle, and asserts `flag_clr` in exactly that cycle. It then requires `match_hit` to be seen in that cycle and `match_flag` to be high one cycle later. A lone clear during the following gap must bring the flag to 0. The bench also lands `abort` inside a gap while a stray `start` is pending earlier in the run, and expects idle on the next edge with the original command still on the wire.

// File: rtl/poll_pkg.sv
package poll_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_INSTR,
        ST_ADDR,
        ST_READ,
        ST_EVAL,
        ST_GAP
    } poll_state_t;

endpackage

// File: rtl/poll_divider.sv
module poll_divider #(
    parameter int PSC_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             late,
    input  logic [PSC_W-1:0] div,
    output logic             bit_end,
    output logic             sample_now,
    output logic             sck_phase
);
    localparam int HW = PSC_W + 1;

    logic [PSC_W-1:0] cnt_q;
    logic [PSC_W-1:0] top_v;
    logic [HW-1:0]    half_v;
    logic [HW-1:0]    cnt_x;

    always_comb begin
        top_v      = (div == '0) ? PSC_W'(1) : div;
        half_v     = (HW'(top_v) + HW'(1)) >> 1;
        cnt_x      = HW'(cnt_q);
        bit_end    = run && (cnt_q == top_v);
        sck_phase  = run && (cnt_x >= half_v);
        sample_now = run && (late ? (cnt_q == top_v)
                                  : (cnt_x == half_v - HW'(1)));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (!run || bit_end)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + PSC_W'(1);
    end

    // R2: a bit never ends while the clock is still in its low half
    a_r2_end_in_high: assert property (@(posedge clk) disable iff (!rst_n)
        bit_end |-> sck_phase);

endmodule

// File: rtl/poll_compare.sv
module poll_compare #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          eval,
    input  logic [DW-1:0] data,
    input  logic [DW-1:0] mask,
    input  logic [DW-1:0] match_val,
    input  logic          clr,
    output logic          hit,
    output logic          flag
);
    logic flag_q;

    always_comb hit = eval && ((data & mask) == match_val);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            flag_q <= 1'b0;
        else if (hit)
            flag_q <= 1'b1;
        else if (clr)
            flag_q <= 1'b0;
    end

    assign flag = flag_q;

    // R10: a same-cycle match beats the clear
    a_r10_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> flag);
    // R10: a lone clear empties the flag
    a_r10_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !hit) |=> !flag);

endmodule

// File: rtl/spi_status_poller.sv
module spi_status_poller
    import poll_pkg::*;
#(
    parameter int DW    = 8,
    parameter int PSC_W = 8,
    parameter int IVL_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             abort,
    input  logic [DW-1:0]    cmd_byte,
    input  logic [DW-1:0]    addr_byte,
    input  logic             use_addr,
    input  logic             use_read,
    input  logic [DW-1:0]    status_mask,
    input  logic [DW-1:0]    status_match,
    input  logic [IVL_W-1:0] gap_periods,
    input  logic [PSC_W-1:0] clk_div,
    input  logic             auto_stop,
    input  logic             late_sample,
    input  logic             flag_clr,
    output logic             sck,
    output logic             cs_n,
    output logic             mosi,
    input  logic             miso,
    output logic             busy,
    output logic             match_hit,
    output logic             match_flag,
    output logic [DW-1:0]    status_byte
);
    localparam int BC_W = $clog2(DW);

    poll_state_t state_q, state_d;

    logic [DW-1:0]    cmd_q, addr_q, mask_q, match_q;
    logic [IVL_W-1:0] gap_q, gapcnt_q;
    logic [PSC_W-1:0] div_q;
    logic             addr_en_q, read_en_q, stop_q, late_q;
    logic [DW-1:0]    tx_q, rx_q, stat_q;
    logic [BC_W-1:0]  bitcnt_q;

    logic shifting, run, bit_end, sample_now, sck_phase, hit;
    logic last_bit, gap_last, in_eval;

    always_comb begin
        last_bit = (bitcnt_q == '0);
        gap_last = (gapcnt_q <= IVL_W'(1));
    end

    poll_divider #(.PSC_W(PSC_W)) u_div (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (run),
        .late       (late_q),
        .div        (div_q),
        .bit_end    (bit_end),
        .sample_now (sample_now),
        .sck_phase  (sck_phase)
    );

    poll_compare #(.DW(DW)) u_cmp (
        .clk       (clk),
        .rst_n     (rst_n),
        .eval      (in_eval),
        .data      (rx_q),
        .mask      (mask_q),
        .match_val (match_q),
        .clr       (flag_clr),
        .hit       (hit),
        .flag      (match_flag)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start) state_d = ST_INSTR;
            ST_INSTR: if (bit_end && last_bit)
                          state_d = addr_en_q ? ST_ADDR
                                  : (read_en_q ? ST_READ : ST_IDLE);
            ST_ADDR:  if (bit_end && last_bit)
                          state_d = read_en_q ? ST_READ : ST_IDLE;
            ST_READ:  if (bit_end && last_bit) state_d = ST_EVAL;
            ST_EVAL:  state_d = (hit && stop_q) ? ST_IDLE : ST_GAP;
            ST_GAP:   if (bit_end && gap_last) state_d = ST_INSTR;
            default:  state_d = ST_IDLE;
        endcase
        if (abort) state_d = ST_IDLE;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // outputs
    always_comb begin
        shifting    = (state_q == ST_INSTR) || (state_q == ST_ADDR) ||
                      (state_q == ST_READ);
        run         = shifting || (state_q == ST_GAP);
        in_eval     = (state_q == ST_EVAL);
        cs_n        = !shifting;
        sck         = shifting && sck_phase;
        mosi        = ((state_q == ST_INSTR) || (state_q == ST_ADDR)) ? tx_q[DW-1] : 1'b0;
        busy        = (state_q != ST_IDLE);
        match_hit   = hit;
        status_byte = stat_q;
    end

    // datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_q <= '0;  addr_q <= '0;  mask_q <= '0;  match_q <= '0;
            gap_q <= '0;  gapcnt_q <= '0;  div_q <= '0;
            addr_en_q <= 1'b0;  read_en_q <= 1'b0;
            stop_q <= 1'b0;  late_q <= 1'b0;
            tx_q <= '0;  rx_q <= '0;  stat_q <= '0;  bitcnt_q <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: if (start) begin
                    cmd_q     <= cmd_byte;
                    addr_q    <= addr_byte;
                    mask_q    <= status_mask;
                    match_q   <= status_match;
                    gap_q     <= gap_periods;
                    div_q     <= clk_div;
                    addr_en_q <= use_addr;
                    read_en_q <= use_read;
                    stop_q    <= auto_stop;
                    late_q    <= late_sample;
                    tx_q      <= cmd_byte;
                    bitcnt_q  <= BC_W'(DW - 1);
                end
                ST_INSTR, ST_ADDR: if (bit_end) begin
                    if (last_bit) begin
                        tx_q     <= addr_q;
                        bitcnt_q <= BC_W'(DW - 1);
                    end else begin
                        tx_q     <= tx_q << 1;
                        bitcnt_q <= bitcnt_q - BC_W'(1);
                    end
                end
                ST_READ: begin
                    if (sample_now) rx_q <= {rx_q[DW-2:0], miso};
                    if (bit_end)    bitcnt_q <= bitcnt_q - BC_W'(1);
                end
                ST_EVAL: begin
                    stat_q   <= rx_q;
                    gapcnt_q <= (gap_q == '0) ? IVL_W'(1) : gap_q;
                end
                ST_GAP: if (bit_end) begin
                    gapcnt_q <= gapcnt_q - IVL_W'(1);
                    if (gap_last) begin
                        tx_q     <= cmd_q;
                        bitcnt_q <= BC_W'(DW - 1);
                    end
                end
                default: ;
            endcase
        end
    end

    // R1: an idle engine keeps the bus quiet
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (cs_n && !sck));
    // R8: no clock edges while deselected
    a_r8_sck_low_deselected: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !sck);
    // R3: data out holds while the clock is high
    a_r3_mosi_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (sck && $past(sck)) |-> $stable(mosi));
    // R6: stop on match
    a_r6_auto_stop: assert property (@(posedge clk) disable iff (!rst_n)
        (match_hit && stop_q) |=> !busy);
    // R7: keep going after a match
    a_r7_keep_polling: assert property (@(posedge clk) disable iff (!rst_n)
        (match_hit && !stop_q && !abort) |=> busy);
    // R9: no compare without a read phase
    a_r9_no_hit_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        match_hit |-> read_en_q);
    // R11: abort reaches idle in one edge
    a_r11_abort: assert property (@(posedge clk) disable iff (!rst_n)
        abort |=> (!busy && cs_n));

endmodule

// File: tb/spi_status_poller_test.sv
module spi_status_poller_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 0, abort = 0, use_addr = 0, use_read = 0;
    logic auto_stop = 0, late_sample = 0, flag_clr = 0;
    logic [7:0] cmd_byte = 0, addr_byte = 0, status_mask = 0, status_match = 0;
    logic [15:0] gap_periods = 0;
    logic [7:0] clk_div = 0;
    logic sck, cs_n, mosi, busy, match_hit, match_flag;
    logic miso = 1'b0;
    logic [7:0] status_byte;

    int total = 0, bad = 0;

    always #4 clk = ~clk;

    spi_status_poller uut (
        .clk(clk), .rst_n(rst_n), .start(start), .abort(abort),
        .cmd_byte(cmd_byte), .addr_byte(addr_byte), .use_addr(use_addr),
        .use_read(use_read), .status_mask(status_mask), .status_match(status_match),
        .gap_periods(gap_periods), .clk_div(clk_div), .auto_stop(auto_stop),
        .late_sample(late_sample), .flag_clr(flag_clr), .sck(sck), .cs_n(cs_n),
        .mosi(mosi), .miso(miso), .busy(busy), .match_hit(match_hit),
        .match_flag(match_flag), .status_byte(status_byte)
    );

    // ---------------- device model ----------------
    int rises = 0, falls = 0, frames = 0, last_bits = 0, hdr = 8, match_at = 1;
    logic [23:0] cap = 0, last_cap = 0;
    logic [7:0] dev_val = 0, good_val = 0, bad_val = 0;
    bit late_drive = 0;
    logic cs_prev = 1'b1, sck_prev = 1'b0;

    task automatic drive_bit(input int j);
        if (j >= 0 && j < 8) miso = dev_val[7-j];
    endtask

    always @(cs_n, sck) begin
        if (cs_n && !cs_prev) begin
            frames++; last_bits = rises; last_cap = cap;
        end else if (!cs_n && cs_prev) begin
            rises = 0; falls = 0; cap = 0; miso = 1'b0;
            dev_val = (frames + 1 >= match_at) ? good_val : bad_val;
        end else if (!cs_n && sck && !sck_prev) begin
            cap = {cap[22:0], mosi}; rises++;
            if (late_drive) drive_bit(rises - hdr - 1);
        end else if (!cs_n && !sck && sck_prev) begin
            falls++;
            if (!late_drive) drive_bit(falls - hdr);
        end
        cs_prev = cs_n; sck_prev = sck;
    end

    // ---------------- clocked monitors ----------------
    int hi_run = 0, lo_run = 0, last_hi = 0, last_lo = 0;
    int gap_run = 0, last_gap = 0, hits = 0;
    always @(negedge clk) begin
        if (!cs_n && sck) hi_run++;
        else if (hi_run > 0) begin last_hi = hi_run; hi_run = 0; end
        if (!cs_n && !sck) lo_run++;
        else if (lo_run > 0) begin last_lo = lo_run; lo_run = 0; end
        if (!busy) gap_run = 0;
        else if (cs_n) gap_run++;
        else if (gap_run > 0) begin last_gap = gap_run; gap_run = 0; end
        if (match_hit) hits++;
    end

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int eff_div(input int d);
        return (d == 0) ? 1 : d;
    endfunction
    function automatic int exp_lo(input int d);
        return (eff_div(d) + 1) / 2;
    endfunction
    function automatic int exp_hi(input int d);
        return eff_div(d) + 1 - exp_lo(d);
    endfunction
    function automatic int exp_gap(input int d, input int g);
        return ((g == 0) ? 1 : g) * (eff_div(d) + 1) + 1;
    endfunction

    task automatic pulse_start();
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
    endtask
    task automatic pulse_clr();
        @(negedge clk) flag_clr = 1'b1;
        @(negedge clk) flag_clr = 1'b0;
    endtask
    task automatic wait_idle();
        do @(negedge clk); while (busy);
    endtask

    task automatic setup(input int d, input int g, input logic [7:0] c, input logic [7:0] a,
                         input bit ae, input bit re, input logic [7:0] m, input logic [7:0] mt,
                         input bit lt, input bit stp);
        @(negedge clk);
        clk_div = 8'(d); gap_periods = 16'(g); cmd_byte = c; addr_byte = a;
        use_addr = ae; use_read = re; status_mask = m; status_match = mt;
        late_sample = lt; late_drive = lt; auto_stop = stp;
        hdr = ae ? 16 : 8; frames = 0; hits = 0; last_gap = 0;
    endtask

    task automatic run_poll(input int d, input int g, input logic [7:0] c, input logic [7:0] a,
                            input bit ae, input logic [7:0] m, input logic [7:0] mt, input bit lt,
                            input int mat, input logic [7:0] gv, input logic [7:0] bv);
        pulse_clr();
        setup(d, g, c, a, ae, 1'b1, m, mt, lt, 1'b1);
        match_at = mat; good_val = gv; bad_val = bv;
        pulse_start();
        wait_idle();
        chk("R6 frames until stop", frames, mat);
        chk("R6 idle after match", busy, 0);
        chk("R3 rising edges", last_bits, ae ? 24 : 16);
        if (ae) chk("R3 header bits", int'(last_cap[23:8]), int'({c, a}));
        else    chk("R3 header bits", int'(last_cap[15:8]), int'(c));
        chk("R4 status byte", int'(status_byte), int'(gv));
        chk("R5 flag set", match_flag, 1);
        chk("R5 one hit", hits, 1);
        chk("R2 high phase", last_hi, exp_hi(d));
        chk("R2 low phase", last_lo, exp_lo(d));
        if (mat >= 2) chk("R8 gap length", last_gap, exp_gap(d, g));
    endtask

    initial begin
        int d, g, mat;
        logic [7:0] m, mt, gv, bv, lowbit;
        bit ae, lt;
        void'($urandom(32'h1357));

        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 busy", busy, 0);
        chk("R1 cs_n", cs_n, 1);
        chk("R1 sck", sck, 0);
        chk("R1 flag", match_flag, 0);
        chk("R1 hit", match_hit, 0);
        rst_n = 1'b1;

        // directed: status bit 1 polled until set
        run_poll(3, 2, 8'h05, 8'hC0, 1, 8'h02, 8'h02, 0, 3, 8'h03, 8'h01);
        // directed: odd divider, late sampling, zero gap, no address
        run_poll(2, 0, 8'h0F, 8'h00, 0, 8'hF0, 8'hA0, 1, 2, 8'hA5, 8'h55);
        // directed: divider 0 behaves as 1
        run_poll(0, 1, 8'h05, 8'hB0, 1, 8'h81, 8'h80, 0, 2, 8'hFE, 8'h7F);

        // constrained random polls
        for (int i = 0; i < 12; i++) begin
            d   = $urandom_range(0, 6);
            g   = $urandom_range(0, 5);
            ae  = 1'($urandom_range(0, 1));
            lt  = 1'($urandom_range(0, 1));
            mat = $urandom_range(1, 3);
            m   = 8'($urandom_range(1, 255));
            mt  = 8'($urandom) & m;
            lowbit = m & (~m + 8'd1);
            gv  = mt | (8'($urandom) & ~m);
            bv  = (mt ^ lowbit) | (8'($urandom) & ~m);
            run_poll(d, g, 8'($urandom), 8'($urandom), ae, m, mt, lt, mat, gv, bv);
        end

        // R7 / R11: no auto-stop, stray start, abort in a gap
        pulse_clr();
        setup(2, 4, 8'h05, 8'hA0, 1, 1, 8'h01, 8'h01, 0, 0);
        match_at = 1; good_val = 8'h01; bad_val = 8'h00;
        pulse_start();
        while (frames < 1) @(negedge clk);
        cmd_byte = 8'h9F;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        while (frames < 3) @(negedge clk);
        @(negedge clk);
        chk("R7 still busy after match", busy, 1);
        abort = 1'b1;
        @(negedge clk) abort = 1'b0;
        chk("R11 idle after abort", busy, 0);
        chk("R11 cs_n after abort", cs_n, 1);
        chk("R7 hit per matching poll", hits, 3);
        chk("R11 stray start ignored", int'(last_cap[23:8]), 16'h05A0);
        chk("R5 flag after polls", match_flag, 1);

        // R10: clear and match in the same cycle
        pulse_clr();
        setup(1, 3, 8'h05, 8'hC0, 1, 1, 8'h08, 8'h08, 0, 0);
        match_at = 1; good_val = 8'h08; bad_val = 8'h00;
        pulse_start();
        while (frames < 1) @(negedge clk);
        chk("R5 hit in first cycle after cs_n rise", match_hit, 1);
        flag_clr = 1'b1;
        @(negedge clk) flag_clr = 1'b0;
        chk("R10 set wins over clear", match_flag, 1);
        flag_clr = 1'b1;
        @(negedge clk) flag_clr = 1'b0;
        chk("R10 lone clear", match_flag, 0);
        abort = 1'b1;
        start = 1'b1;
        @(negedge clk) begin abort = 1'b0; start = 1'b0; end
        chk("R11 abort beats start", busy, 0);

        // R9: command-only frames leave the flag alone
        run_poll(1, 1, 8'h05, 8'hC0, 1, 8'h01, 8'h01, 0, 1, 8'h01, 8'h00);
        setup(1, 1, 8'h06, 8'h00, 0, 0, 8'hFF, 8'h00, 0, 1);
        good_val = 8'h00; bad_val = 8'h00;
        pulse_start();
        wait_idle();
        chk("R9 single frame", frames, 1);
        chk("R9 edges command only", last_bits, 8);
        chk("R9 command byte", int'(last_cap[7:0]), 8'h06);
        chk("R9 no hit", hits, 0);
        chk("R9 flag kept", match_flag, 1);
        setup(3, 1, 8'h04, 8'h3C, 1, 0, 8'hFF, 8'h00, 0, 1);
        pulse_start();
        wait_idle();
        chk("R9 single frame with address", frames, 1);
        chk("R9 edges with address", last_bits, 16);
        chk("R9 command and address", int'(last_cap[15:0]), 16'h043C);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=expired expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule